// File: doc/BRIEF.md
# Local Memory Transfer Unit for a Custom Functional Unit

This block is a tagless byte memory placed inside an application-specific functional unit, together with a copy engine that moves whole arrays between main memory and the local memory. The processor loads a source and a destination address with two register-write commands. It then starts either an inbound copy (main to local) or an outbound copy (local to main) with a byte length. Each copy follows a fixed cost model. The first byte lands a long, fixed number of cycles after the start command, and every later byte follows a short, fixed number of cycles after the one before it.

A typical flow works like this. The whole array is copied in before an accelerated loop runs. During the loop, the loop's byte loads and stores go to the local memory by direct offset and never reach main memory. The array is written back to main memory only if software issues an outbound command. A small bank of scalar state registers sits beside the memory. Software writes and reads these registers directly, with no copy setup.

Top module: `lmem_dma_unit`

## Requirements
- R1: `cmd_op` encodes 0 = load source address, 1 = load destination address, 2 = inbound copy (main[src+i] to local[dst+i]), 3 = outbound copy (local[src+i] to main[dst+i]), for i = 0 .. `cmd_len`-1. The addresses come from `cmd_addr`, and local offsets wrap modulo the local depth (1024 bytes).
- R2: Byte i of a copy moves on clock edge 18+2*i after the edge that accepts the start command. `busy` is high for exactly 18+2*(len-1) cycles.
- R3: `busy` rises in the cycle after an accepted start. `done` is a single-cycle pulse in the cycle right after `busy` falls.
- R4: Main memory is written (`mm_we`) only during an outbound copy. An inbound copy and local accesses never write main memory.
- R5: When idle, a load (`ld_valid`) returns local[`ls_addr`] on `ld_rdata` with `ld_rvalid` one cycle later. A store (`st_valid`) writes `st_data` to local[`ls_addr`]. If a load and a store hit the same cycle, the load returns the old byte.
- R6: While `busy` is high, any load or store request raises `ls_stall` and has no effect on the local memory or on `ld_rvalid`.
- R7: A start command received while `busy` is high is ignored and sets the sticky `err` flag, which only reset clears.
- R8: A start command with a length of zero is ignored. It raises neither `busy` nor `err`.
- R9: Scalar register `sc_sel` takes `sc_wdata` on a cycle with `sc_we` and is read combinationally on `sc_rdata`. It works while a copy is running, and copies do not affect it.
- R10: After reset, `busy`, `done`, `err`, `ld_rvalid`, `mm_we` and `mm_re` are low, and every scalar register reads zero.
- R11: Address registers persist across copies. Loading one while a copy is running does not change the running copy, and the next copy uses the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | Command code (R1) |
| cmd_addr | input | 11 | Address for the load-address commands |
| cmd_len | input | 11 | Byte length for start commands |
| ld_valid | input | 1 | Local load request |
| st_valid | input | 1 | Local store request |
| ls_addr | input | 10 | Local byte offset for load/store |
| st_data | input | 8 | Store byte |
| ls_stall | output | 1 | Load/store refused because a copy is running |
| ld_rvalid | output | 1 | Load data valid |
| ld_rdata | output | 8 | Load data |
| sc_we | input | 1 | Scalar register write strobe |
| sc_sel | input | 2 | Scalar register index |
| sc_wdata | input | 32 | Scalar write data |
| sc_rdata | output | 32 | Scalar read data |
| busy | output | 1 | Copy in progress |
| done | output | 1 | Copy-complete pulse |
| err | output | 1 | Sticky start-while-busy flag |
| mm_addr | output | 11 | Main memory byte address |
| mm_re | output | 1 | Main memory read strobe |
| mm_we | output | 1 | Main memory write strobe |
| mm_wdata | output | 8 | Main memory write byte |
| mm_rdata | input | 8 | Main memory read byte (same cycle) |

## Verification
The assertions check the timing relations on every cycle. `done` is always a lone pulse following a fall of `busy`. Main-memory strokes never fall in back-to-back cycles and only occur while busy. A stall only occurs during a copy. `err` never drops, and `busy` only rises after a command. Only the bench scenarios can show the byte-level results and the exact durations: the cycle count for lengths 1, 4 and 16, the data landing at the right wrapped offsets, both memory images after a round trip, the loss of stalled stores, and the reuse of address registers that were changed mid-copy.

// File: rtl/lmx_pkg.sv
// Shared command encoding for the local memory transfer unit.
// Assumes a two-bit command field; the code values are part of the
// software interface and must not be renumbered.
package lmx_pkg;
    typedef enum logic [1:0] {
        LMX_SET_SRC = 2'd0,
        LMX_SET_DST = 2'd1,
        LMX_GO_IN   = 2'd2,
        LMX_GO_OUT  = 2'd3
    } lmx_op_e;
endpackage

// File: rtl/lmx_cmd_regs.sv
// Command decoder: holds the two address registers, qualifies start
// commands and keeps the sticky error flag.
// Assumes the sequencer's busy output reflects the registered state,
// so a start seen in the same cycle as the last byte is still refused.
module lmx_cmd_regs
    import lmx_pkg::*;
#(
    parameter int MAW  = 11,
    parameter int LENW = 11
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_valid,
    input  logic [1:0]      cmd_op,
    input  logic [MAW-1:0]  cmd_addr,
    input  logic [LENW-1:0] cmd_len,
    input  logic            busy,
    output logic [MAW-1:0]  src_q,
    output logic [MAW-1:0]  dst_q,
    output logic            start,
    output logic            start_out,
    output logic            err
);
    lmx_op_e op;
    logic    is_go;

    // Decode the command code and qualify a start request.
    always_comb begin
        op        = lmx_op_e'(cmd_op);
        is_go     = (op == LMX_GO_IN) || (op == LMX_GO_OUT);
        start     = cmd_valid && is_go && !busy && (cmd_len != '0);
        start_out = (op == LMX_GO_OUT);
    end

    // Address registers, written by the two load-address commands.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q <= '0;
            dst_q <= '0;
        end else if (cmd_valid) begin
            if (op == LMX_SET_SRC) src_q <= cmd_addr;
            if (op == LMX_SET_DST) dst_q <= cmd_addr;
        end
    end

    // Sticky error: a start arriving during a running copy.
    always_ff @(posedge clk) begin
        if (!rst_n)                       err <= 1'b0;
        else if (cmd_valid && is_go && busy) err <= 1'b1;
    end
endmodule

// File: rtl/lmx_dma_seq.sv
// Copy sequencer: latches a copy request, counts the first-byte and
// next-byte costs and produces one move strobe per byte with the
// matching main and local addresses.
// Assumes FIRST_COST >= 1 and NEXT_COST >= 1; start only arrives idle.
module lmx_dma_seq #(
    parameter int MAW        = 11,
    parameter int LAW        = 10,
    parameter int LENW       = 11,
    parameter int FIRST_COST = 18,
    parameter int NEXT_COST  = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            start_out,
    input  logic [MAW-1:0]  src_addr,
    input  logic [MAW-1:0]  dst_addr,
    input  logic [LENW-1:0] len,
    output logic            busy,
    output logic            done,
    output logic            step,
    output logic            to_main,
    output logic [MAW-1:0]  main_addr,
    output logic [LAW-1:0]  local_addr
);
    localparam int MAXC = (FIRST_COST > NEXT_COST) ? FIRST_COST : NEXT_COST;
    localparam int CW   = $clog2(MAXC + 1);

    logic [CW-1:0]   wait_q;
    logic [LENW-1:0] idx_q;
    logic [LENW-1:0] len_q;
    logic [MAW-1:0]  src_q;
    logic [MAW-1:0]  dst_q;
    logic            last_byte;

    // A byte moves in the cycle where the cost counter reaches one.
    always_comb begin
        step      = busy && (wait_q == CW'(1));
        last_byte = (idx_q + 1'b1) == len_q;
    end

    // Request latch, cost counter and byte index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            done    <= 1'b0;
            to_main <= 1'b0;
            wait_q  <= '0;
            idx_q   <= '0;
            len_q   <= '0;
            src_q   <= '0;
            dst_q   <= '0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (start) begin
                    busy    <= 1'b1;
                    to_main <= start_out;
                    wait_q  <= CW'(FIRST_COST);
                    idx_q   <= '0;
                    len_q   <= len;
                    src_q   <= src_addr;
                    dst_q   <= dst_addr;
                end
            end else if (step) begin
                idx_q <= idx_q + 1'b1;
                if (last_byte) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end else begin
                    wait_q <= CW'(NEXT_COST);
                end
            end else begin
                wait_q <= wait_q - 1'b1;
            end
        end
    end

    // Byte addresses on both sides of the current move.
    always_comb begin
        main_addr  = (to_main ? dst_q : src_q) + MAW'(idx_q);
        local_addr = (to_main ? src_q[LAW-1:0] : dst_q[LAW-1:0]) + LAW'(idx_q);
    end
endmodule

// File: rtl/lmx_local_ram.sv
// Tagless byte memory: one write port, one combinational read port for
// the copy engine, one registered read port for loads.
// Assumes the caller never asks for a load and a copy read that conflict.
module lmx_local_ram #(
    parameter int DEPTH = 1024,
    parameter int LAW   = 10
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [LAW-1:0] wr_addr,
    input  logic [7:0]     wr_data,
    input  logic [LAW-1:0] dma_raddr,
    output logic [7:0]     dma_rdata,
    input  logic           ld_en,
    input  logic [LAW-1:0] ld_addr,
    output logic           ld_rvalid,
    output logic [7:0]     ld_rdata
);
    logic [7:0] mem [DEPTH];

    // Storage write; contents are not cleared by reset.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    // Copy-engine read, same cycle.
    always_comb dma_rdata = mem[dma_raddr];

    // Load read, one cycle latency; sees the byte before a same-cycle write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ld_rvalid <= 1'b0;
            ld_rdata  <= '0;
        end else begin
            ld_rvalid <= ld_en;
            if (ld_en) ld_rdata <= mem[ld_addr];
        end
    end
endmodule

// File: rtl/lmx_scalar_bank.sv
// Bank of directly written scalar state registers with a combinational
// read by index. Assumes NSC is a power of two so every index is valid.
module lmx_scalar_bank #(
    parameter int NSC  = 4,
    parameter int SCW  = 32,
    parameter int SELW = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic [SELW-1:0] sel,
    input  logic [SCW-1:0]  wdata,
    output logic [SCW-1:0]  rdata
);
    logic [SCW-1:0] bank [NSC];

    for (genvar g = 0; g < NSC; g++) begin : g_reg
        logic [SCW-1:0] val_q;
        // One scalar register, cleared by reset.
        always_ff @(posedge clk) begin
            if (!rst_n)                          val_q <= '0;
            else if (we && (sel == SELW'(g)))    val_q <= wdata;
        end
        assign bank[g] = val_q;
    end

    // Read selected register.
    always_comb rdata = bank[sel];
endmodule

// File: rtl/lmem_dma_unit.sv
// Local memory transfer unit top: command registers, copy sequencer,
// local byte memory and scalar bank. Loads and stores are refused
// while a copy runs; the main memory port answers reads in the same cycle.
module lmem_dma_unit #(
    parameter int MAW        = 11,
    parameter int LDEPTH     = 1024,
    parameter int FIRST_COST = 18,
    parameter int NEXT_COST  = 2,
    parameter int NSC        = 4,
    parameter int SCW        = 32,
    localparam int LAW       = $clog2(LDEPTH),
    localparam int LENW      = LAW + 1,
    localparam int SELW      = $clog2(NSC)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_valid,
    input  logic [1:0]      cmd_op,
    input  logic [MAW-1:0]  cmd_addr,
    input  logic [LENW-1:0] cmd_len,
    input  logic            ld_valid,
    input  logic            st_valid,
    input  logic [LAW-1:0]  ls_addr,
    input  logic [7:0]      st_data,
    output logic            ls_stall,
    output logic            ld_rvalid,
    output logic [7:0]      ld_rdata,
    input  logic            sc_we,
    input  logic [SELW-1:0] sc_sel,
    input  logic [SCW-1:0]  sc_wdata,
    output logic [SCW-1:0]  sc_rdata,
    output logic            busy,
    output logic            done,
    output logic            err,
    output logic [MAW-1:0]  mm_addr,
    output logic            mm_re,
    output logic            mm_we,
    output logic [7:0]      mm_wdata,
    input  logic [7:0]      mm_rdata
);
    logic [MAW-1:0] src_q, dst_q, main_addr;
    logic [LAW-1:0] local_addr, ram_waddr;
    logic           start, start_out, step, to_main;
    logic           ld_fire, st_fire, ram_we;
    logic [7:0]     ram_wdata, dma_rdata;

    lmx_cmd_regs #(.MAW(MAW), .LENW(LENW)) u_cmd (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_len(cmd_len), .busy(busy),
        .src_q(src_q), .dst_q(dst_q), .start(start), .start_out(start_out),
        .err(err)
    );

    lmx_dma_seq #(.MAW(MAW), .LAW(LAW), .LENW(LENW),
                  .FIRST_COST(FIRST_COST), .NEXT_COST(NEXT_COST)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .start_out(start_out),
        .src_addr(src_q), .dst_addr(dst_q), .len(cmd_len),
        .busy(busy), .done(done), .step(step), .to_main(to_main),
        .main_addr(main_addr), .local_addr(local_addr)
    );

    // Gate local accesses behind a running copy and steer the write port.
    always_comb begin
        ld_fire   = ld_valid && !busy;
        st_fire   = st_valid && !busy;
        ls_stall  = busy && (ld_valid || st_valid);
        ram_we    = (step && !to_main) || st_fire;
        ram_waddr = busy ? local_addr : ls_addr;
        ram_wdata = busy ? mm_rdata : st_data;
    end

    lmx_local_ram #(.DEPTH(LDEPTH), .LAW(LAW)) u_ram (
        .clk(clk), .rst_n(rst_n), .wr_en(ram_we), .wr_addr(ram_waddr),
        .wr_data(ram_wdata), .dma_raddr(local_addr), .dma_rdata(dma_rdata),
        .ld_en(ld_fire), .ld_addr(ls_addr), .ld_rvalid(ld_rvalid),
        .ld_rdata(ld_rdata)
    );

    lmx_scalar_bank #(.NSC(NSC), .SCW(SCW), .SELW(SELW)) u_sc (
        .clk(clk), .rst_n(rst_n), .we(sc_we), .sel(sc_sel),
        .wdata(sc_wdata), .rdata(sc_rdata)
    );

    // Main memory port drive.
    always_comb begin
        mm_addr  = main_addr;
        mm_re    = step && !to_main;
        mm_we    = step && to_main;
        mm_wdata = dma_rdata;
    end
endmodule

// File: rtl/lmem_dma_unit_chk.sv
// Timing checker for the local memory transfer unit, bound to the top.
// Assumes NEXT_COST >= 2 so byte moves never fall on adjacent cycles.
module lmem_dma_unit_chk (
    input logic clk,
    input logic rst_n,
    input logic cmd_valid,
    input logic busy,
    input logic done,
    input logic err,
    input logic ls_stall,
    input logic mm_re,
    input logic mm_we
);
    // R3
    done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));
    // R3
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R3
    busy_fall_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);
    // R3
    busy_rise_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(cmd_valid));
    // R4
    main_write_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mm_we || mm_re) |-> busy);
    // R2
    byte_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mm_we || mm_re) |=> !(mm_we || mm_re));
    // R6
    stall_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ls_stall |-> busy);
    // R7
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);
endmodule

bind lmem_dma_unit lmem_dma_unit_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .busy(busy),
    .done(done), .err(err), .ls_stall(ls_stall), .mm_re(mm_re), .mm_we(mm_we)
);

// File: tb/lmem_dma_unit_bench.sv
// Bench: behavioural reference model compared on every clock, plus
// scenario checks of durations and memory images.
module lmem_dma_unit_bench;
    localparam int MD = 2048;
    localparam int LD = 1024;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = '0;
    logic [10:0] cmd_addr = '0;
    logic [10:0] cmd_len = '0;
    logic        ld_valid = 1'b0, st_valid = 1'b0;
    logic [9:0]  ls_addr = '0;
    logic [7:0]  st_data = '0;
    logic        ls_stall, ld_rvalid;
    logic [7:0]  ld_rdata;
    logic        sc_we = 1'b0;
    logic [1:0]  sc_sel = '0;
    logic [31:0] sc_wdata = '0, sc_rdata;
    logic        busy, done, err;
    logic [10:0] mm_addr;
    logic        mm_re, mm_we;
    logic [7:0]  mm_wdata, mm_rdata;

    logic [7:0]  mm_arr   [MD];
    logic [7:0]  exp_main [MD];
    logic [7:0]  m_lmem   [LD];
    bit          m_known  [LD];
    logic [31:0] exp_sc   [4];

    int compared = 0, mismatched = 0;
    bit m_busy, m_done, m_err, m_rv, m_in, pre;
    logic [7:0] m_rd;
    int m_wait, m_i, m_len, m_src, m_dst, m_srcreg, m_dstreg;

    lmem_dma_unit u_lmem_dma_unit (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_len(cmd_len), .ld_valid(ld_valid),
        .st_valid(st_valid), .ls_addr(ls_addr), .st_data(st_data),
        .ls_stall(ls_stall), .ld_rvalid(ld_rvalid), .ld_rdata(ld_rdata),
        .sc_we(sc_we), .sc_sel(sc_sel), .sc_wdata(sc_wdata), .sc_rdata(sc_rdata),
        .busy(busy), .done(done), .err(err), .mm_addr(mm_addr), .mm_re(mm_re),
        .mm_we(mm_we), .mm_wdata(mm_wdata), .mm_rdata(mm_rdata)
    );

    always #4 clk = ~clk;  // 125 MHz

    // Main memory model: same-cycle read, write on the edge.
    assign mm_rdata = mm_arr[mm_addr];
    always @(posedge clk) if (mm_we) mm_arr[mm_addr] <= mm_wdata;

    task automatic chk(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Reference model, advanced on every edge from the requirements.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_done = 0; m_err = 0; m_rv = 0;
            m_srcreg = 0; m_dstreg = 0;
            for (int k = 0; k < 4; k++) exp_sc[k] = '0;
        end else begin
            pre = m_busy; m_done = 0; m_rv = 0;
            if (pre) begin
                if (m_wait == 1) begin
                    if (m_in) begin
                        m_lmem[(m_dst + m_i) % LD] = exp_main[(m_src + m_i) % MD];
                        m_known[(m_dst + m_i) % LD] = 1;
                    end else begin
                        exp_main[(m_dst + m_i) % MD] = m_lmem[(m_src + m_i) % LD];
                    end
                    m_i++;
                    if (m_i == m_len) begin m_busy = 0; m_done = 1; end
                    else m_wait = 2;
                end else m_wait--;
            end else begin
                if (ld_valid) begin m_rv = 1; m_rd = m_lmem[ls_addr]; end
                if (st_valid) begin m_lmem[ls_addr] = st_data; m_known[ls_addr] = 1; end
            end
            if (cmd_valid) begin
                case (cmd_op)
                    2'd0: m_srcreg = int'(cmd_addr);
                    2'd1: m_dstreg = int'(cmd_addr);
                    default: begin
                        if (pre) m_err = 1;
                        else if (cmd_len != 0) begin
                            m_busy = 1; m_wait = 18; m_i = 0; m_len = int'(cmd_len);
                            m_in = (cmd_op == 2'd2); m_src = m_srcreg; m_dst = m_dstreg;
                        end
                    end
                endcase
            end
            if (sc_we) exp_sc[sc_sel] = sc_wdata;
        end
    end

    // Per-cycle comparison away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            chk(busy == m_busy, "R3 busy", 32'(busy), 32'(m_busy));
            chk(done == m_done, "R3 done", 32'(done), 32'(m_done));
            chk(err == m_err, "R7 err", 32'(err), 32'(m_err));
            chk(ls_stall == (m_busy && (ld_valid || st_valid)), "R6 stall",
                32'(ls_stall), 32'(m_busy && (ld_valid || st_valid)));
            chk(ld_rvalid == m_rv, "R5 ld_rvalid", 32'(ld_rvalid), 32'(m_rv));
            if (m_rv && m_known[ls_addr] !== 1'bx)
                chk(ld_rdata == m_rd, "R5 ld_rdata", 32'(ld_rdata), 32'(m_rd));
            chk(!mm_we || (m_busy && !m_in), "R4 mm_we", 32'(mm_we), 32'(0));
            chk(sc_rdata == exp_sc[sc_sel], "R9 sc_rdata", sc_rdata, exp_sc[sc_sel]);
        end
    end

    task automatic tick; @(posedge clk); #1; endtask

    task automatic cmd(input int op, input int addr, input int len);
        cmd_valid = 1; cmd_op = 2'(op); cmd_addr = 11'(addr); cmd_len = 11'(len);
        tick();
        cmd_valid = 0;
    endtask

    task automatic go_wait(input int op, input int len, input string tag);
        int dur = 0;
        cmd(op, 0, len);
        while (busy && dur < 5000) begin dur++; tick(); end
        chk(dur == 18 + 2 * (len - 1), tag, 32'(dur), 32'(18 + 2 * (len - 1)));
        chk(done == 1'b1, "R3 done after copy", 32'(done), 32'(1));
    endtask

    task automatic lrd(input int a, output logic [7:0] d);
        ld_valid = 1; ls_addr = 10'(a); tick(); ld_valid = 0; d = ld_rdata;
    endtask

    task automatic lwr(input int a, input int d);
        st_valid = 1; ls_addr = 10'(a); st_data = 8'(d); tick(); st_valid = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        chk(0, "watchdog", 0, 1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        logic [7:0] d;
        int bad;
        for (int k = 0; k < MD; k++) begin
            mm_arr[k] = 8'((k * 7 + 3) ^ (k >> 8));
            exp_main[k] = mm_arr[k];
        end
        for (int k = 0; k < LD; k++) m_known[k] = 0;
        repeat (3) tick();
        rst_n = 1; tick();
        // R10 reset state
        chk(!busy && !done && !err && !ld_rvalid && !mm_we && !mm_re, "R10 reset",
            {busy, done, err, ld_rvalid, mm_we, mm_re}, 0);
        chk(sc_rdata == 0, "R10 scalar reset", sc_rdata, 0);

        // R9 scalar write/read
        sc_we = 1; sc_sel = 2; sc_wdata = 32'hCAFE0102; tick();
        sc_sel = 1; sc_wdata = 32'h11223344; tick(); sc_we = 0;
        sc_sel = 2; #1 chk(sc_rdata == 32'hCAFE0102, "R9 scalar", sc_rdata, 32'hCAFE0102);

        // R8 zero length ignored
        cmd(2, 0, 0);
        chk(!busy && !err, "R8 zero length", {busy, err}, 0);

        // R1 R2 inbound 16 bytes from main 0x100 to local 0x20
        cmd(0, 'h100, 0); cmd(1, 'h20, 0);
        go_wait(2, 16, "R2 inbound len16");
        for (int k = 0; k < 16; k++) begin
            lrd('h20 + k, d);
            chk(d == mm_arr['h100 + k], "R1 inbound byte", d, mm_arr['h100 + k]);
        end

        // R2 single byte boundary, outbound local 0x20 -> main 0x500
        cmd(0, 'h20, 0); cmd(1, 'h500, 0);
        go_wait(3, 1, "R2 outbound len1");
        chk(mm_arr['h500] == mm_arr['h100], "R1 outbound byte", mm_arr['h500], mm_arr['h100]);

        // R5 store then same-cycle load/store returns old byte
        lwr(5, 'hA5);
        ld_valid = 1; st_valid = 1; ls_addr = 5; st_data = 8'h3C; tick();
        ld_valid = 0; st_valid = 0;
        chk(ld_rdata == 8'hA5, "R5 old byte", ld_rdata, 8'hA5);
        lrd(5, d); chk(d == 8'h3C, "R5 store", d, 8'h3C);

        // R6 R7 R11 activity while a 4-byte inbound copy runs
        cmd(0, 'h300, 0); cmd(1, 'h40, 0);
        cmd(2, 0, 4);
        cmd(3, 0, 2);                        // refused start
        chk(err == 1'b1, "R7 err set", 32'(err), 32'(1));
        cmd(0, 'h600, 0);                    // new source while busy
        st_valid = 1; ls_addr = 5; st_data = 8'hEE; tick();
        chk(ls_stall == 1'b1, "R6 stall", 32'(ls_stall), 32'(1));
        st_valid = 0;
        sc_we = 1; sc_sel = 0; sc_wdata = 32'h5A5A; tick(); sc_we = 0;
        while (busy) tick();
        lrd(5, d); chk(d == 8'h3C, "R6 stalled store lost", d, 8'h3C);
        for (int k = 0; k < 4; k++) begin
            lrd('h40 + k, d);
            chk(d == mm_arr['h300 + k], "R11 running copy unchanged", d, mm_arr['h300 + k]);
        end
        cmd(1, 'h80, 0);
        go_wait(2, 4, "R2 inbound len4");
        lrd('h80, d); chk(d == mm_arr['h600], "R11 new source used", d, mm_arr['h600]);
        chk(err == 1'b1, "R7 err sticky", 32'(err), 32'(1));

        // R1 wrap of local offset: main 0x700 -> local 1020, 8 bytes
        cmd(0, 'h700, 0); cmd(1, 1020, 0);
        go_wait(2, 8, "R2 inbound len8");
        lrd(2, d); chk(d == mm_arr['h706], "R1 wrap", d, mm_arr['h706]);

        // R1 R4 round trip: local 0x20 (main 0x100 copy) -> main 0x400
        cmd(0, 'h20, 0); cmd(1, 'h400, 0);
        go_wait(3, 16, "R2 outbound len16");
        bad = 0;
        for (int k = 0; k < 16; k++) if (mm_arr['h400 + k] != mm_arr['h100 + k]) bad++;
        chk(bad == 0, "R1 round trip image", bad, 0);
        bad = 0;
        for (int k = 0; k < MD; k++) if (mm_arr[k] != exp_main[k]) bad++;
        chk(bad == 0, "R4 main image", bad, 0);

        repeat (2) tick();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule